// File: doc/BRIEF.md
# CRT Timing Register Bank

This block is the register file behind a CRT timing controller. Software reaches it through two I/O ports. The pointer port holds a five-bit selector. The data port reads or writes the register that the selector names. Eight registers are implemented at slots 0 through 7:

- Six horizontal timing values: total, display end, blank start, blank end, sync start and sync end.
- The low byte of the vertical total.
- A high-bit register. It supplies the ninth bit of five vertical quantities.

Two protect inputs come from an extension register outside this block. Each one locks a group of registers. Inside the high-bit register, each one locks a subset of the bits rather than the whole byte.

Only the low five selector bits are decoded. Any 8-bit value written to the pointer port therefore lands in one of 32 slots. Every 32-entry range of the index space reaches the same registers. The timing values are driven to the outputs, with the 9-bit vertical total reassembled. The outputs carry these values only while the adapter-state input says the controller owns the display.

Top module: `crtc_regfile`

## Requirements
- R1: Reset clears the selector, every register and every timing output. The pointer port and the data port both read 0 afterwards.
- R2: A write on the pointer port (`port_sel`=0) keeps bits 4..0 of the data. Reading the pointer port returns those bits, with bits 7..5 read as 0.
- R3: Data-port accesses use the selector modulo 32. Pointer values 0x00+s, 0x20+s, …, 0xE0+s all reach slot s.
- R4: While `prot[0]`=1, a data write leaves slots 0, 2, 3, 4, 5 and 6 unchanged. While `prot[0]`=0, these slots take the written byte.
- R5: While `prot[1]`=1, a data write leaves slot 1 (horizontal display end) unchanged. While `prot[1]`=0, slot 1 takes the written byte.
- R6: In slot 7, bits 0, 2 and 3 are locked by `prot[0]`, and bits 1 and 4 are locked by `prot[1]`. Unlocked bits of the same byte still update. Bits 7..5 always read 0.
- R7: With `vga_mode`=1, the outputs are mapped as follows:
  - `h_total`, `h_disp_end`, `h_blank_start`, `h_blank_end`, `h_sync_start` and `h_sync_end` equal slots 0, 1, 2, 3, 4 and 5.
  - `v_total` equals {slot7[0], slot6}.
  - `v_disp_end_b8`, `v_sync_start_b8`, `v_blank_start_b8` and `line_cmp_b8` equal slot 7 bits 1, 2, 3 and 4.
- R8: With `vga_mode`=0, every timing output is 0. The registers keep their contents and stay readable and writable.
- R9: A data-port read returns the selected slot combinationally, in the same cycle, and changes no state. Slots 8..31 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the port chosen by `port_sel` |
| port_sel | input | 1 | 0 = pointer port, 1 = data port |
| wdata | input | 8 | Write data |
| prot | input | 2 | Write-protect control bits from the extension register |
| vga_mode | input | 1 | Adapter-state input; 1 lets the timing values drive the outputs |
| rdata | output | 8 | Read data of the port chosen by `port_sel` (combinational) |
| h_total | output | 8 | Horizontal total |
| h_disp_end | output | 8 | Horizontal display end |
| h_blank_start | output | 8 | Horizontal blank start |
| h_blank_end | output | 8 | Horizontal blank end byte |
| h_sync_start | output | 8 | Horizontal sync start |
| h_sync_end | output | 8 | Horizontal sync end byte |
| v_total | output | 9 | Vertical total with its ninth bit |
| v_disp_end_b8 | output | 1 | Ninth bit of vertical display end |
| v_sync_start_b8 | output | 1 | Ninth bit of vertical sync start |
| v_blank_start_b8 | output | 1 | Ninth bit of vertical blank start |
| line_cmp_b8 | output | 1 | Ninth bit of line compare |

## Verification
A wrong selector appears on the pointer port at once, and on the data port it shows up as a read of the wrong slot. A broken lock mask is visible one clock after the offending write. The data-port readback shows it and, in VGA mode, so do the timing outputs. The bench therefore sweeps every pointer value and every protect combination across every slot, and compares the readback with a bank model after each write. A fault in the high-bit register shows up as a wrong ninth bit of `v_total` or of the per-field outputs, in the same cycle as the readback.

// File: rtl/crtc_rf_pkg.sv
package crtc_rf_pkg;
  localparam int DW       = 8;
  localparam int IW       = 5;
  localparam int NREG     = 8;
  localparam int HDE_SLOT = 1;
  localparam int VT_SLOT  = 6;
  localparam int OVF_SLOT = 7;

  // bits of a data-port write allowed through for a slot under the protect bits
  function automatic logic [DW-1:0] wr_allow(input logic [IW-1:0] slot, input logic [1:0] prot);
    logic [DW-1:0] m;
    if (slot == IW'(OVF_SLOT))
      m = {3'b000, ~prot[1], ~prot[0], ~prot[0], ~prot[1], ~prot[0]};
    else if (slot == IW'(HDE_SLOT))
      m = {DW{~prot[1]}};
    else
      m = {DW{~prot[0]}};
    return m;
  endfunction

  function automatic logic [DW-1:0] merge_bits(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [DW-1:0] allow);
    return (old_v & ~allow) | (new_v & allow);
  endfunction
endpackage

// File: rtl/crtc_index_reg.sv
module crtc_index_reg #(
  parameter int DW = 8,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [IW-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (load) idx <= din[IW-1:0];
  end
endmodule

// File: rtl/crtc_reg_bank.sv
module crtc_reg_bank
  import crtc_rf_pkg::*;
#(
  parameter int NR = NREG
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IW-1:0]          slot,
  input  logic [DW-1:0]          wdata,
  input  logic [1:0]             prot,
  output logic [NR-1:0][DW-1:0]  regs
);
  logic [DW-1:0] allow;
  assign allow = wr_allow(slot, prot);

  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic hit;
    assign hit = we && (slot == IW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   regs[g] <= '0;
      else if (hit) regs[g] <= merge_bits(regs[g], wdata, allow);
    end
  end
endmodule

// File: rtl/crtc_timing_map.sv
module crtc_timing_map
  import crtc_rf_pkg::*;
(
  input  logic [NREG-1:0][DW-1:0] regs,
  input  logic                    vga_mode,
  output logic [DW-1:0]           h_total,
  output logic [DW-1:0]           h_disp_end,
  output logic [DW-1:0]           h_blank_start,
  output logic [DW-1:0]           h_blank_end,
  output logic [DW-1:0]           h_sync_start,
  output logic [DW-1:0]           h_sync_end,
  output logic [DW:0]             v_total,
  output logic                    v_disp_end_b8,
  output logic                    v_sync_start_b8,
  output logic                    v_blank_start_b8,
  output logic                    line_cmp_b8
);
  logic [DW-1:0] hi;
  assign hi = regs[OVF_SLOT];

  always_comb begin
    h_total          = '0;
    h_disp_end       = '0;
    h_blank_start    = '0;
    h_blank_end      = '0;
    h_sync_start     = '0;
    h_sync_end       = '0;
    v_total          = '0;
    v_disp_end_b8    = 1'b0;
    v_sync_start_b8  = 1'b0;
    v_blank_start_b8 = 1'b0;
    line_cmp_b8      = 1'b0;
    if (vga_mode) begin
      h_total          = regs[0];
      h_disp_end       = regs[1];
      h_blank_start    = regs[2];
      h_blank_end      = regs[3];
      h_sync_start     = regs[4];
      h_sync_end       = regs[5];
      v_total          = {hi[0], regs[VT_SLOT]};
      v_disp_end_b8    = hi[1];
      v_sync_start_b8  = hi[2];
      v_blank_start_b8 = hi[3];
      line_cmp_b8      = hi[4];
    end
  end
endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_rf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          port_sel,
  input  logic [7:0]    wdata,
  input  logic [1:0]    prot,
  input  logic          vga_mode,
  output logic [7:0]    rdata,
  output logic [7:0]    h_total,
  output logic [7:0]    h_disp_end,
  output logic [7:0]    h_blank_start,
  output logic [7:0]    h_blank_end,
  output logic [7:0]    h_sync_start,
  output logic [7:0]    h_sync_end,
  output logic [8:0]    v_total,
  output logic          v_disp_end_b8,
  output logic          v_sync_start_b8,
  output logic          v_blank_start_b8,
  output logic          line_cmp_b8
);
  logic [IW-1:0]           idx;
  logic [NREG-1:0][DW-1:0] regs;
  logic                    idx_load;
  logic                    data_we;
  logic                    slot_mapped;
  logic [DW-1:0]           slot_rd;

  assign idx_load    = wr_en && !port_sel;
  assign slot_mapped = (idx < IW'(NREG));
  assign data_we     = wr_en && port_sel && slot_mapped;

  crtc_index_reg #(.DW(DW), .IW(IW)) u_idx (
    .clk(clk), .rst_n(rst_n), .load(idx_load), .din(wdata), .idx(idx)
  );

  crtc_reg_bank #(.NR(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(data_we), .slot(idx),
    .wdata(wdata), .prot(prot), .regs(regs)
  );

  crtc_timing_map u_map (
    .regs(regs), .vga_mode(vga_mode),
    .h_total(h_total), .h_disp_end(h_disp_end), .h_blank_start(h_blank_start),
    .h_blank_end(h_blank_end), .h_sync_start(h_sync_start), .h_sync_end(h_sync_end),
    .v_total(v_total), .v_disp_end_b8(v_disp_end_b8), .v_sync_start_b8(v_sync_start_b8),
    .v_blank_start_b8(v_blank_start_b8), .line_cmp_b8(line_cmp_b8)
  );

  always_comb begin
    slot_rd = '0;
    for (int i = 0; i < NREG; i++)
      if (idx == IW'(i)) slot_rd = regs[i];
  end

  assign rdata = port_sel ? slot_rd : {{(DW-IW){1'b0}}, idx};
endmodule

// File: rtl/crtc_regfile_chk.sv
module crtc_regfile_chk
  import crtc_rf_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic                    port_sel,
  input logic [1:0]              prot,
  input logic                    vga_mode,
  input logic [IW-1:0]           idx,
  input logic [NREG-1:0][DW-1:0] regs,
  input logic [7:0]              rdata,
  input logic [7:0]              h_total,
  input logic [8:0]              v_total
);
  logic wr_slot0, wr_slot1, wr_slot7;
  assign wr_slot0 = wr_en && port_sel && (idx == 5'd0);
  assign wr_slot1 = wr_en && port_sel && (idx == 5'd1);
  assign wr_slot7 = wr_en && port_sel && (idx == 5'd7);

  p_ptr_high_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !port_sel |-> rdata[7:5] == 3'b000);

  p_lock_group0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_slot0 && prot[0]) |=> regs[0] == $past(regs[0]));

  p_lock_hde_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_slot1 && prot[1]) |=> regs[1] == $past(regs[1]));

  p_hi_lock0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_slot7 && prot[0]) |=> (regs[7][0] == $past(regs[7][0])) &&
                              (regs[7][3:2] == $past(regs[7][3:2])));

  p_hi_lock1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_slot7 && prot[1]) |=> (regs[7][1] == $past(regs[7][1])) &&
                              (regs[7][4] == $past(regs[7][4])));

  p_hi_unused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    regs[7][7:5] == 3'b000);

  p_vtot_join_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vga_mode |-> v_total == {regs[7][0], regs[6]});

  p_mode_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vga_mode |-> (h_total == 8'd0) && (v_total == 9'd0));

  p_read_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(idx) && (regs == $past(regs)));
endmodule

bind crtc_regfile crtc_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel), .prot(prot),
  .vga_mode(vga_mode), .idx(idx), .regs(regs), .rdata(rdata),
  .h_total(h_total), .v_total(v_total)
);

// File: tb/sim_crtc_regfile.sv
module sim_crtc_regfile;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       port_sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [1:0] prot = 2'b00;
  logic       vga_mode = 1'b1;
  logic [7:0] rdata, h_total, h_disp_end, h_blank_start, h_blank_end, h_sync_start, h_sync_end;
  logic [8:0] v_total;
  logic       v_disp_end_b8, v_sync_start_b8, v_blank_start_b8, line_cmp_b8;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] m [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  crtc_regfile u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel), .wdata(wdata),
    .prot(prot), .vga_mode(vga_mode), .rdata(rdata),
    .h_total(h_total), .h_disp_end(h_disp_end), .h_blank_start(h_blank_start),
    .h_blank_end(h_blank_end), .h_sync_start(h_sync_start), .h_sync_end(h_sync_end),
    .v_total(v_total), .v_disp_end_b8(v_disp_end_b8), .v_sync_start_b8(v_sync_start_b8),
    .v_blank_start_b8(v_blank_start_b8), .line_cmp_b8(line_cmp_b8)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic ps, input logic [7:0] d);
    @(negedge clk);
    port_sel = ps; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic ps, output logic [7:0] v);
    port_sel = ps;
    #1;
    v = rdata;
  endtask

  // per-bit lock rule, stated bit by bit
  function automatic logic bit_open(input int slot, input int b, input logic [1:0] p);
    if (slot == 7) begin
      if (b >= 5) return 1'b0;
      if (b == 1 || b == 4) return !p[1];
      return !p[0];
    end
    if (slot == 1) return !p[1];
    return !p[0];
  endfunction

  task automatic model_write(input int slot, input logic [7:0] d, input logic [1:0] p);
    if (slot < 8)
      for (int b = 0; b < 8; b++)
        if (bit_open(slot, b, p)) m[slot][b] = d[b];
  endtask

  function automatic string tag_of(input int slot);
    if (slot == 7) return "R6";
    if (slot == 1) return "R5";
    return "R4";
  endfunction

  task automatic check_outputs(input string req);
    #1;
    check({req, " h_total"},   h_total,       vga_mode ? m[0] : 8'h0);
    check({req, " h_de"},      h_disp_end,    vga_mode ? m[1] : 8'h0);
    check({req, " h_bs"},      h_blank_start, vga_mode ? m[2] : 8'h0);
    check({req, " h_be"},      h_blank_end,   vga_mode ? m[3] : 8'h0);
    check({req, " h_ss"},      h_sync_start,  vga_mode ? m[4] : 8'h0);
    check({req, " h_se"},      h_sync_end,    vga_mode ? m[5] : 8'h0);
    check({req, " v_total"},   v_total,       vga_mode ? {m[7][0], m[6]} : 9'h0);
    check({req, " b8 fields"}, {v_disp_end_b8, v_sync_start_b8, v_blank_start_b8, line_cmp_b8},
          vga_mode ? {m[7][1], m[7][2], m[7][3], m[7][4]} : 4'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 8; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    peek(1'b0, v); check("R1 pointer", v, 8'h00);
    peek(1'b1, v); check("R1 data", v, 8'h00);
    check_outputs("R1");

    // R2: every pointer value
    for (int i = 0; i < 256; i++) begin
      put(1'b0, 8'(i));
      peek(1'b0, v); check("R2 pointer", v, i & 8'h1f);
    end

    // R3: write through one alias range, read through another
    for (int s = 0; s < 8; s++) begin
      logic [7:0] d;
      d = 8'(8'hA5 ^ (s * 37));
      put(1'b0, 8'(s + 32 * s));
      put(1'b1, d);
      model_write(s, d, 2'b00);
      put(1'b0, 8'(s + 32 * (7 - s)));
      peek(1'b1, v); check("R3 alias", v, m[s]);
    end

    // R4 R5 R6: every protect combination on every slot
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 8; s++) begin
        logic [7:0] d;
        d = ~m[s] ^ 8'(p << 3);
        prot = 2'(p);
        put(1'b0, 8'(s + 64 * p));
        put(1'b1, d);
        model_write(s, d, 2'(p));
        prot = 2'b00;
        put(1'b0, 8'(s));
        peek(1'b1, v); check(tag_of(s), v, m[s]);
      end
    end

    // R9: unmapped slots read 0, writes reach no register
    for (int s = 8; s < 32; s++) begin
      put(1'b0, 8'(s));
      put(1'b1, 8'hff);
      peek(1'b1, v); check("R9 unmapped", v, 8'h00);
    end
    for (int s = 0; s < 8; s++) begin
      put(1'b0, 8'(s + 128));
      peek(1'b1, v); check("R9 bank intact", v, m[s]);
      @(negedge clk);
      peek(1'b1, v); check("R9 read repeat", v, m[s]);
      peek(1'b0, v); check("R9 pointer kept", v, 8'(s));
    end

    // R7: output mapping under several patterns
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 8; s++) begin
        logic [7:0] d;
        d = 8'((s * 29 + k * 83 + 7) ^ (k[0] ? 8'hff : 8'h00));
        put(1'b0, 8'(s));
        put(1'b1, d);
        model_write(s, d, 2'b00);
      end
      check_outputs("R7");
    end

    // R8: mode off zeroes outputs, bank still reachable
    vga_mode = 1'b0;
    check_outputs("R8");
    put(1'b0, 8'd6);
    put(1'b1, 8'h3c);
    model_write(6, 8'h3c, 2'b00);
    peek(1'b1, v); check("R8 data port", v, 8'h3c);
    check_outputs("R8");
    vga_mode = 1'b1;
    check_outputs("R7 restored");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule